// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Controller

This block keeps the per-vector message table of an MSI-X capable function together with the array of pending bits. Each vector has an entry with a 64-bit message address, a 32-bit message data word and a one-bit mask. An agent inside the function raises an interrupt by presenting a vector number. The block either turns that request into a message (address plus data) on a valid/ready output, or records it as pending when the vector or the whole function is masked.

Software reaches the table and the pending array through a simple register port that supports 32-bit and 64-bit accesses. The table and the pending array are told apart by a select input. The configuration-space logic outside the block decodes the Message Control word and passes in three of its fields: the enable bit (bit 15), the function-mask bit (bit 14), and the table-size field (bits 10:0, holding the vector count minus one).

Pending messages are replayed in two cases. The first is when software clears a vector's mask bit. The second is when the function mask falls; every unmasked, pending vector is then scheduled, and the messages go out lowest vector first.

Top module: `msix_vec_ctrl`

## Requirements
- R1: A table entry occupies 16 bytes at entry index = offset/16. The 32-bit locations within an entry are: 0x0 = address low, 0x4 = address high, 0x8 = data, 0xC = vector control. Only bit 0 of vector control is stored (1 = masked), and its other bits read as zero.
- R2: A 64-bit table access at entry offset 0x0 carries the address, with the high half in bits 63:32. A 64-bit access at offset 0x8 carries the data in bits 31:0 and the vector control in bits 63:32.
- R3: Table accesses at any other offset/width combination, or to an entry index at or above the vector count, read as zero and leave the table unchanged.
- R4: With the pending select set, the pending bit of vector v sits at 64-bit word v/64, bit v%64. A 64-bit read at word offset 0 returns the whole word. A 32-bit read at offset 0 returns bits 31:0, and at offset 4 returns bits 63:32.
- R5: Register writes with the pending select set change no pending bit.
- R6: An accepted request on an unmasked vector, while the function is unmasked, raises msgValid on the second rising edge after the request is sampled. The message carries that entry's address and data.
- R7: A request on a masked vector, or while the function mask is set, sends no message and sets the vector's pending bit.
- R8: When a write clears a vector's mask bit while the function is unmasked and the vector is pending, the block sends that vector's message and then clears its pending bit.
- R9: When the function mask falls, every pending vector that is unmasked is sent, in ascending vector order. Pending vectors that are still masked stay pending.
- R10: While the enable bit is 0, requests are dropped. A request whose vector is above the table-size field is also dropped. A dropped request sends no message and sets no pending bit.
- R11: While msgValid is high and msgReady is low, msgValid and the message stay unchanged, and a pending bit is cleared only on the edge where its message handshake completes.
- R12: After reset, all table fields, mask bits and pending bits are zero, and msgValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regEn | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regPba | input | 1 | 1 = pending array, 0 = vector table |
| regWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| regAddr | input | AW | Byte offset within the selected region |
| regWrData | input | 64 | Write data; a 32-bit access uses bits 31:0 |
| regRdData | output | 64 | Read data, combinational from the address inputs |
| ctlEnable | input | 1 | Message Control enable bit |
| ctlFnMask | input | 1 | Message Control function-mask bit |
| ctlTblSize | input | 11 | Message Control table-size field (vector count minus one) |
| reqValid | input | 1 | Interrupt request strobe |
| reqVec | input | VW | Requested vector number |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message accepted when high together with msgValid |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |

## Verification
Register reads are combinational, so the bench samples regRdData a few nanoseconds after it drives the address, inside the same cycle. A request changes the internal schedule on the edge that samples it, and msgValid rises on the next edge. The bench checks msgValid at the falling edges around both of those edges. A mask-clearing write and a fall of the function mask each schedule on the edge that sees them, so their messages are also due two edges later, and a function unmask sends its messages one per cycle while msgReady is high. Every expected message is queued before its stimulus is applied, and a monitor pops the queue on each handshake seen at a falling edge. Idle windows of several cycles then confirm that no extra message appeared.

// File: rtl/msix_vec_pkg.sv
package msix_vec_pkg;
  localparam int MAX_VECTORS = 2048;

  // one-cycle strobes from the scheduler to the table datapath
  typedef struct packed {
    logic setPend;   // blocked request records pending
    logic parkPend;  // scheduled vector became masked: back to pending
    logic clrPend;   // message handshake done
  } pendStrobe_t;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_vec_pkg::*;
#(
  parameter int NUM_VEC = 40,
  localparam int VW = $clog2(NUM_VEC),
  localparam int AW = VW + 4,
  localparam int PW = (NUM_VEC + 63) / 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regEn,
  input  logic               regWr,
  input  logic               regPba,
  input  logic               regWide,
  input  logic [AW-1:0]      regAddr,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  input  pendStrobe_t        strobe,
  input  logic [VW-1:0]      setIdx,
  input  logic [VW-1:0]      parkIdx,
  input  logic [VW-1:0]      clrIdx,
  input  logic [VW-1:0]      outVec,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData,
  output logic [NUM_VEC-1:0] vecMask,
  output logic [NUM_VEC-1:0] pendBits,
  output logic               unmaskHit,
  output logic [VW-1:0]      unmaskIdx
);
  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] msgDat [NUM_VEC];

  logic [VW-1:0] entry;
  logic [3:0]    off;
  logic          entryOk, tblWr, wrLo, wrHi, wrDat, wrCtl, ctlVal;
  logic [31:0]   hiVal;

  assign entry   = regAddr[AW-1:4];
  assign off     = regAddr[3:0];
  assign entryOk = int'(entry) < NUM_VEC;
  assign tblWr   = regEn && regWr && !regPba && entryOk;
  assign wrLo    = tblWr && (off == 4'h0);
  assign wrHi    = tblWr && (regWide ? (off == 4'h0) : (off == 4'h4));
  assign wrDat   = tblWr && (off == 4'h8);
  assign wrCtl   = tblWr && (regWide ? (off == 4'h8) : (off == 4'hC));
  assign hiVal   = regWide ? regWrData[63:32] : regWrData[31:0];
  assign ctlVal  = regWide ? regWrData[32] : regWrData[0];

  assign unmaskHit = wrCtl && vecMask[entry] && !ctlVal;
  assign unmaskIdx = entry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        addrLo[v] <= '0;
        addrHi[v] <= '0;
        msgDat[v] <= '0;
      end
      vecMask  <= '0;
      pendBits <= '0;
    end else begin
      if (wrLo)  addrLo[entry]  <= regWrData[31:0];
      if (wrHi)  addrHi[entry]  <= hiVal;
      if (wrDat) msgDat[entry]  <= regWrData[31:0];
      if (wrCtl) vecMask[entry] <= ctlVal;
      // clear first so a same-cycle set wins
      if (strobe.clrPend)  pendBits[clrIdx]  <= 1'b0;
      if (strobe.parkPend) pendBits[parkIdx] <= 1'b1;
      if (strobe.setPend)  pendBits[setIdx]  <= 1'b1;
    end
  end

  assign msgAddr = {addrHi[outVec], addrLo[outVec]};
  assign msgData = msgDat[outVec];

  // pending array as 64-bit words
  logic [PW*64-1:0] pendPad;
  logic [63:0]      pbaWords [PW];
  assign pendPad = (PW*64)'(pendBits);
  for (genvar w = 0; w < PW; w++) begin : g_pbaWord
    assign pbaWords[w] = pendPad[w*64 +: 64];
  end

  logic [63:0] pbaSel;
  always_comb begin
    pbaSel = '0;
    for (int w = 0; w < PW; w++)
      if (int'(regAddr[AW-1:3]) == w) pbaSel = pbaWords[w];
  end

  always_comb begin
    regRdData = '0;
    if (regPba) begin
      case ({regWide, regAddr[2:0]})
        4'b1_000: regRdData = pbaSel;
        4'b0_000: regRdData = {32'b0, pbaSel[31:0]};
        4'b0_100: regRdData = {32'b0, pbaSel[63:32]};
        default:  regRdData = '0;
      endcase
    end else if (entryOk) begin
      case ({regWide, off})
        5'h00:   regRdData = {32'b0, addrLo[entry]};
        5'h04:   regRdData = {32'b0, addrHi[entry]};
        5'h08:   regRdData = {32'b0, msgDat[entry]};
        5'h0C:   regRdData = {63'b0, vecMask[entry]};
        5'h10:   regRdData = {addrHi[entry], addrLo[entry]};
        5'h18:   regRdData = {31'b0, vecMask[entry], msgDat[entry]};
        default: regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/msix_vec_sched.sv
module msix_vec_sched
  import msix_vec_pkg::*;
#(
  parameter int NUM_VEC = 40,
  localparam int VW = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VW-1:0]      reqVec,
  input  logic               ctlEnable,
  input  logic               ctlFnMask,
  input  logic [10:0]        ctlTblSize,
  input  logic [NUM_VEC-1:0] vecMask,
  input  logic [NUM_VEC-1:0] pendBits,
  input  logic               unmaskHit,
  input  logic [VW-1:0]      unmaskIdx,
  input  logic               msgReady,
  output logic               msgValid,
  output logic [VW-1:0]      outVec,
  output pendStrobe_t        strobe,
  output logic [VW-1:0]      setIdx,
  output logic [VW-1:0]      parkIdx,
  output logic [VW-1:0]      clrIdx
);
  logic [NUM_VEC-1:0] due, dueNext, elig, parkable;
  logic               fnMaskQ, fnFall, inRange, accept, blocked, handshake, load;
  logic               pickFound, parkFound;
  logic [VW-1:0]      pickIdx;

  assign inRange   = (int'(reqVec) < NUM_VEC) && (11'(reqVec) <= ctlTblSize);
  assign accept    = reqValid && ctlEnable && inRange;
  assign blocked   = ctlFnMask || vecMask[reqVec];
  assign fnFall    = fnMaskQ && !ctlFnMask;
  assign handshake = msgValid && msgReady;
  assign elig      = due & ~vecMask & {NUM_VEC{ctlEnable && !ctlFnMask}};
  assign parkable  = due & (vecMask | {NUM_VEC{ctlFnMask}}) & {NUM_VEC{ctlEnable}};
  assign load      = pickFound && (!msgValid || handshake);

  // lowest index first for both finders
  always_comb begin
    pickFound = 1'b0;
    pickIdx   = '0;
    parkFound = 1'b0;
    parkIdx   = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (elig[v]) begin
        pickFound = 1'b1;
        pickIdx   = VW'(v);
      end
      if (parkable[v]) begin
        parkFound = 1'b1;
        parkIdx   = VW'(v);
      end
    end
  end

  assign strobe.setPend  = accept && blocked;
  assign strobe.parkPend = parkFound;
  assign strobe.clrPend  = handshake;
  assign setIdx          = reqVec;
  assign clrIdx          = outVec;

  always_comb begin
    dueNext = due;
    if (fnFall) dueNext = dueNext | (pendBits & ~vecMask);
    if (unmaskHit && !ctlFnMask && pendBits[unmaskIdx]) dueNext[unmaskIdx] = 1'b1;
    if (load) dueNext[pickIdx] = 1'b0;
    if (parkFound) dueNext[parkIdx] = 1'b0;
    if (accept && !blocked) dueNext[reqVec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      due      <= '0;
      fnMaskQ  <= 1'b0;
      msgValid <= 1'b0;
      outVec   <= '0;
    end else begin
      due     <= dueNext;
      fnMaskQ <= ctlFnMask;
      if (handshake) msgValid <= 1'b0;
      if (load) begin
        msgValid <= 1'b1;
        outVec   <= pickIdx;
      end
    end
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_vec_pkg::*;
#(
  parameter int NUM_VEC = 40,
  localparam int VW = $clog2(NUM_VEC),
  localparam int AW = VW + 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regEn,
  input  logic          regWr,
  input  logic          regPba,
  input  logic          regWide,
  input  logic [AW-1:0] regAddr,
  input  logic [63:0]   regWrData,
  output logic [63:0]   regRdData,
  input  logic          ctlEnable,
  input  logic          ctlFnMask,
  input  logic [10:0]   ctlTblSize,
  input  logic          reqValid,
  input  logic [VW-1:0] reqVec,
  output logic          msgValid,
  input  logic          msgReady,
  output logic [63:0]   msgAddr,
  output logic [31:0]   msgData
);
  pendStrobe_t        strobe;
  logic [VW-1:0]      setIdx, parkIdx, clrIdx, outVec, unmaskIdx;
  logic [NUM_VEC-1:0] vecMask, pendBits;
  logic               unmaskHit;

  msix_vec_table #(.NUM_VEC(NUM_VEC)) table_i (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regPba(regPba),
    .regWide(regWide), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe), .setIdx(setIdx), .parkIdx(parkIdx),
    .clrIdx(clrIdx), .outVec(outVec), .msgAddr(msgAddr), .msgData(msgData),
    .vecMask(vecMask), .pendBits(pendBits), .unmaskHit(unmaskHit),
    .unmaskIdx(unmaskIdx)
  );

  msix_vec_sched #(.NUM_VEC(NUM_VEC)) sched_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVec(reqVec),
    .ctlEnable(ctlEnable), .ctlFnMask(ctlFnMask), .ctlTblSize(ctlTblSize),
    .vecMask(vecMask), .pendBits(pendBits), .unmaskHit(unmaskHit),
    .unmaskIdx(unmaskIdx), .msgReady(msgReady), .msgValid(msgValid),
    .outVec(outVec), .strobe(strobe), .setIdx(setIdx), .parkIdx(parkIdx),
    .clrIdx(clrIdx)
  );
endmodule

// File: rtl/msix_vec_chk.sv
module msix_vec_chk #(
  parameter int NUM_VEC = 40,
  localparam int VW = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               ctlEnable,
  input logic               ctlFnMask,
  input logic               msgValid,
  input logic               msgReady,
  input logic [VW-1:0]      outVec,
  input logic [NUM_VEC-1:0] vecMask,
  input logic [NUM_VEC-1:0] pendBits
);
  logic               prevValid, prevReady, prevEnable, prevFnMask, prevHeld;
  logic [NUM_VEC-1:0] prevMask;
  logic [VW-1:0]      prevOut;
  logic               newMsg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid  <= 1'b0;
      prevReady  <= 1'b0;
      prevEnable <= 1'b0;
      prevFnMask <= 1'b0;
      prevHeld   <= 1'b0;
      prevMask   <= '0;
      prevOut    <= '0;
    end else begin
      prevValid  <= msgValid;
      prevReady  <= msgReady;
      prevEnable <= ctlEnable;
      prevFnMask <= ctlFnMask;
      prevHeld   <= msgValid && !msgReady && pendBits[outVec];
      prevMask   <= vecMask;
      prevOut    <= outVec;
    end
  end

  // a message that appeared on the last edge
  assign newMsg = msgValid && (!prevValid || prevReady);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(outVec)));

  a_r11_pend_kept: assert property (@(posedge clk) disable iff (!rstN)
    prevHeld |-> pendBits[prevOut]);

  a_r7_vec_masked: assert property (@(posedge clk) disable iff (!rstN)
    newMsg |-> !prevMask[outVec]);

  a_r7_fn_masked: assert property (@(posedge clk) disable iff (!rstN)
    newMsg |-> !prevFnMask);

  a_r10_disabled: assert property (@(posedge clk) disable iff (!rstN)
    newMsg |-> prevEnable);
endmodule

bind msix_vec_ctrl msix_vec_chk #(.NUM_VEC(NUM_VEC)) chk_i (
  .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .ctlFnMask(ctlFnMask),
  .msgValid(msgValid), .msgReady(msgReady), .outVec(outVec),
  .vecMask(vecMask), .pendBits(pendBits)
);

// File: tb/msix_vec_ctrl_tb_top.sv
module msix_vec_ctrl_tb_top;
  localparam int NV = 40;
  localparam int VW = $clog2(NV);
  localparam int AW = VW + 4;

  logic          clk = 0, rstN = 0;
  logic          regEn = 0, regWr = 0, regPba = 0, regWide = 0;
  logic [AW-1:0] regAddr = '0;
  logic [63:0]   regWrData = '0, regRdData;
  logic          ctlEnable = 0, ctlFnMask = 0;
  logic [10:0]   ctlTblSize = 11'd39;
  logic          reqValid = 0;
  logic [VW-1:0] reqVec = '0;
  logic          msgValid, msgReady = 1;
  logic [63:0]   msgAddr;
  logic [31:0]   msgData;

  int nTests = 0, nFail = 0;
  logic [95:0] expQ [$];

  always #10 clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(NV)) dut_i (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regPba(regPba),
    .regWide(regWide), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ctlEnable(ctlEnable), .ctlFnMask(ctlFnMask),
    .ctlTblSize(ctlTblSize), .reqValid(reqValid), .reqVec(reqVec),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  function automatic logic [31:0] loOf(int v);  return 32'hA000_0000 | 32'(v << 4); endfunction
  function automatic logic [31:0] hiOf(int v);  return 32'h0000_0100 + 32'(v);      endfunction
  function automatic logic [31:0] datOf(int v); return 32'hD000_0000 + 32'(v);      endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: handshake is seen at the falling edge before it happens
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      if (expQ.size() == 0) begin
        nTests++; nFail++;
        $display("FAIL R6/R7/R10: unexpected message actual %h_%h expected none", msgAddr, msgData);
      end else begin
        logic [95:0] e;
        e = expQ.pop_front();
        check("R6/R8/R9 message", {msgAddr, msgData}, e);
      end
    end
  end

  task automatic expectMsg(int v);
    expQ.push_back({hiOf(v), loOf(v), datOf(v)});
  endtask

  task automatic regWrite(logic pba, logic wide, int addr, logic [63:0] d);
    @(posedge clk); #2;
    regEn = 1; regWr = 1; regPba = pba; regWide = wide; regAddr = AW'(addr); regWrData = d;
    @(posedge clk); #2;
    regEn = 0; regWr = 0;
  endtask

  task automatic regRead(logic pba, logic wide, int addr, output logic [63:0] q);
    @(posedge clk); #2;
    regEn = 1; regWr = 0; regPba = pba; regWide = wide; regAddr = AW'(addr);
    #5 q = regRdData;
    regEn = 0;
  endtask

  task automatic sendReq(int v);
    @(posedge clk); #2;
    reqValid = 1; reqVec = VW'(v);
    @(posedge clk); #2;
    reqValid = 0;
  endtask

  task automatic drain(string req, int n);
    repeat (n) @(posedge clk);
    check(req, 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [63:0] q;
    repeat (3) @(posedge clk);
    #2 rstN = 1;

    // R12: reset state
    @(negedge clk);
    check("R12 msgValid", 64'(msgValid), 64'd0);
    regRead(0, 1, 0, q);          check("R12 entry0 addr", q, 64'd0);
    regRead(0, 0, 16*7 + 8, q);   check("R12 entry7 data", q, 64'd0);
    regRead(1, 1, 0, q);          check("R12 pending", q, 64'd0);

    // program all entries: even ones 64-bit, odd ones 32-bit
    for (int v = 0; v < NV; v++) begin
      if (v % 2 == 0) begin
        regWrite(0, 1, v*16,     {hiOf(v), loOf(v)});
        regWrite(0, 1, v*16 + 8, {32'd0, datOf(v)});
      end else begin
        regWrite(0, 0, v*16,     {32'd0, loOf(v)});
        regWrite(0, 0, v*16 + 4, {32'd0, hiOf(v)});
        regWrite(0, 0, v*16 + 8, {32'd0, datOf(v)});
      end
    end

    // R1: 32-bit layout
    regRead(0, 0, 3*16,     q); check("R1 addr lo", q, {32'd0, loOf(3)});
    regRead(0, 0, 3*16 + 4, q); check("R1 addr hi", q, {32'd0, hiOf(3)});
    regRead(0, 0, 3*16 + 8, q); check("R1 data",    q, {32'd0, datOf(3)});
    regRead(0, 0, 3*16 + 12, q); check("R1 vctl",   q, 64'd0);
    regWrite(0, 0, 2*16 + 12, 64'hFFFF_FFFF);
    regRead(0, 0, 2*16 + 12, q); check("R1 vctl bit0 only", q, 64'd1);
    // R2: 64-bit layout
    regRead(0, 1, 4*16, q);      check("R2 wide addr", q, {hiOf(4), loOf(4)});
    regRead(0, 1, 2*16 + 8, q);  check("R2 wide data+vctl", q, {32'd1, datOf(2)});
    regWrite(0, 1, 2*16 + 8, {32'd0, datOf(2)});
    regRead(0, 0, 2*16 + 12, q); check("R2 wide vctl write", q, 64'd0);

    // R3: undefined offsets and out-of-range entries
    regRead(0, 1, 3*16 + 4, q);  check("R3 wide odd offset read", q, 64'd0);
    regWrite(0, 0, 3*16 + 2, 64'hFFFF_FFFF);
    regRead(0, 0, 3*16, q);      check("R3 unaligned write ignored", q, {32'd0, loOf(3)});
    regWrite(0, 1, 1*16 + 4, 64'hFFFF_FFFF_FFFF_FFFF);
    regRead(0, 1, 1*16, q);      check("R3 wide write ignored", q, {hiOf(1), loOf(1)});
    regRead(0, 0, 45*16, q);     check("R3 entry beyond count", q, 64'd0);

    // R6: plain delivery and its latency
    @(posedge clk); #2 ctlEnable = 1;
    expectMsg(3);
    @(posedge clk); #2 reqValid = 1; reqVec = 3;
    @(negedge clk); check("R6 idle before sample", 64'(msgValid), 64'd0);
    @(posedge clk); #2 reqValid = 0;
    @(negedge clk); check("R6 low after first edge", 64'(msgValid), 64'd0);
    @(negedge clk); check("R6 high after second edge", 64'(msgValid), 64'd1);
    drain("R6 delivered", 3);

    // R7/R8/R11: vector mask, pending, replay held by ready
    @(posedge clk); #2 msgReady = 0;
    regWrite(0, 0, 5*16 + 12, 64'd1);
    sendReq(5);
    drain("R7 masked vector silent", 4);
    regRead(1, 1, 0, q);         check("R7 pending set", q, 64'd1 << 5);
    expectMsg(5);
    regWrite(0, 0, 5*16 + 12, 64'd0);
    repeat (4) @(negedge clk);
    check("R11 valid held", 64'(msgValid), 64'd1);
    regRead(1, 1, 0, q);         check("R11 pending kept until handshake", q, 64'd1 << 5);
    @(posedge clk); #2 msgReady = 1;
    drain("R8 replay sent", 3);
    regRead(1, 1, 0, q);         check("R8 pending cleared", q, 64'd0);

    // R9/R4: function mask, ordered replay, masked vector stays pending
    regWrite(0, 0, 9*16 + 12, 64'd1);
    @(posedge clk); #2 ctlFnMask = 1;
    sendReq(20); sendReq(7); sendReq(33); sendReq(9);
    drain("R7 function mask silent", 4);
    regRead(1, 1, 0, q);
    check("R4 wide pending word", q, (64'd1 << 7) | (64'd1 << 9) | (64'd1 << 20) | (64'd1 << 33));
    regRead(1, 0, 4, q);         check("R4 upper half", q, 64'd2);
    regRead(1, 0, 0, q);         check("R4 lower half", q, 64'h0010_0280);
    regRead(1, 1, 8, q);         check("R4 word beyond count", q, 64'd0);
    expectMsg(7); expectMsg(20); expectMsg(33);
    @(posedge clk); #2 ctlFnMask = 0;
    drain("R9 ordered replay", 8);
    regRead(1, 1, 0, q);         check("R9 masked stays pending", q, 64'd1 << 9);

    // R5: pending array is read-only
    regWrite(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    regRead(1, 1, 0, q);         check("R5 write ones ignored", q, 64'd1 << 9);
    regWrite(1, 0, 0, 64'd0);
    regRead(1, 1, 0, q);         check("R5 write zero ignored", q, 64'd1 << 9);

    // R10: disable and table size
    @(posedge clk); #2 ctlEnable = 0;
    sendReq(2);
    drain("R10 disabled drop", 4);
    @(posedge clk); #2 ctlEnable = 1; ctlTblSize = 11'd7;
    sendReq(10);
    drain("R10 beyond size drop", 4);
    regRead(1, 1, 0, q);         check("R10 no pending from drops", q, 64'd1 << 9);
    expectMsg(6);
    sendReq(6);
    drain("R10 in size delivered", 4);
    @(posedge clk); #2 ctlTblSize = 11'd39;

    // R8: final vector unmask releases the parked request
    expectMsg(9);
    regWrite(0, 0, 9*16 + 12, 64'd0);
    drain("R8 unmask vector 9", 4);
    regRead(1, 1, 0, q);         check("R8 pending empty", q, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule